// File: doc/BRIEF.md
# Serial Memory Slave Front-End with Hold

This block is the bit-level front end of a serial-bus memory slave. It watches chip select, the serial clock, serial data in and an active-low hold line. All four are sampled on a fast system clock through two-flop synchronisers. Data in is captured on rising serial-clock edges, most significant bit first. Each completed byte is handed to the back end as a one-cycle strobe. The same strobe tells the back end that it may load the next outgoing byte. That byte is then shifted out on falling edges, one bit per edge and MSB first, through a data output with its own enable. Bus polarity mode 0 (clock idles low) and mode 3 (clock idles high) both work without configuration, because only edges are acted on.

A hold line lets the master pause a transfer without losing the bit position. Hold is entered and left only while the serial clock is low. A change of the hold line made while the clock is high takes effect at the next low phase. After reset the block stays locked until it has seen chip select fall. Raising chip select clears the whole front end. At that moment it reports whether the bits clocked so far formed whole bytes. The back end uses that report to decide whether a write may start.

Top module: `spi_hold_frontend`

## Requirements
- R1: Data in is sampled on each rising serial-clock edge while the block is selected and not held. Bits are assembled MSB first. After the eighth sampled bit, `rx_valid_o` pulses for one system clock, and `rx_byte_o` holds the byte during that pulse. The same applies in mode 0 and in mode 3.
- R2: `bit_cnt_o` gives the number of bits sampled in the current byte, from 0 to 7. It returns to 0 in the cycle of the `rx_valid_o` pulse.
- R3: While chip select is high, `sdo_oe_o` is 0 and `bit_cnt_o` is 0. A partly received byte is discarded and never reported.
- R4: After reset, serial-clock activity is ignored until a falling edge of chip select has been seen. A chip select that is already low when reset is released does not select the block.
- R5: `tx_req_o` pulses together with `rx_valid_o`. A byte loaded through `tx_load_i` appears on `sdo_o` MSB first, one bit per falling serial-clock edge, starting at the first falling edge after the load. A byte loaded before the last falling edge of the current byte continues the stream with no gap. `sdo_oe_o` is 1 from that first falling edge until deselect or hold.
- R6: The hold condition starts when the hold line is low while the serial clock is low, and ends when the hold line is high while the serial clock is low. A change of the hold line made during a high clock phase is deferred until the clock goes low. The falling edge that ends a deferred hold entry is still acted on.
- R7: During hold, `sdo_oe_o` is 0, and serial-clock and data-in transitions are ignored. The bit count and both shift registers keep their values, and the transfer resumes where it stopped.
- R8: Hold can be entered only while the block is selected. Raising chip select during hold ends the hold and resets the front end, so the next selection starts a fresh byte.
- R9: On each rising edge of chip select after the block has been unlocked, `desel_o` pulses for one cycle. During that pulse, `desel_aligned_o` is 1 exactly when the bit count was 0, meaning the bits received formed whole bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for oversampling |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock from the bus master |
| cs_n_i | input | 1 | Chip select, active low |
| sdi_i | input | 1 | Serial data in |
| hold_n_i | input | 1 | Pause request, active low |
| sdo_o | output | 1 | Serial data out value |
| sdo_oe_o | output | 1 | Output enable for `sdo_o`; 0 means high impedance |
| rx_valid_o | output | 1 | One-cycle strobe for a completed received byte |
| rx_byte_o | output | W | Received byte, valid with `rx_valid_o` |
| bit_cnt_o | output | $clog2(W) | Bits sampled in the current byte |
| tx_req_o | output | 1 | Request for the next outgoing byte |
| tx_load_i | input | 1 | Loads `tx_byte_i` as the next outgoing byte |
| tx_byte_i | input | W | Outgoing byte |
| desel_o | output | 1 | One-cycle strobe on chip-select rise |
| desel_aligned_o | output | 1 | With `desel_o`: 1 when the transfer ended on a byte boundary |

## Verification
Bytes are exchanged with the clock idling low and with it idling high. This shows that only edges matter and not the idle level. A streamed read of two loaded bytes separates correct MSB-first falling-edge output from off-by-one-edge shifting. Hold is applied once during a low clock phase and once during a high one. Junk clock pulses are sent during hold. The high-phase case shows whether entry and exit are deferred to the low phase, and the junk pulses show that position and data survive the pause. A chip select that is low at reset, a deselect during hold, and transfers ending on and off a byte boundary exercise the lockout, reset and alignment paths.

// File: rtl/spi_hold_frontend.sv
module spi_hold_frontend #(
  parameter int W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sck_i,
  input  logic                 cs_n_i,
  input  logic                 sdi_i,
  input  logic                 hold_n_i,
  output logic                 sdo_o,
  output logic                 sdo_oe_o,
  output logic                 rx_valid_o,
  output logic [W-1:0]         rx_byte_o,
  output logic [$clog2(W)-1:0] bit_cnt_o,
  output logic                 tx_req_o,
  input  logic                 tx_load_i,
  input  logic [W-1:0]         tx_byte_i,
  output logic                 desel_o,
  output logic                 desel_aligned_o
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [1:0] sck_m, cs_m, sdi_m, hold_m;
  logic sck_d, cs_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_m  <= '0;
      cs_m   <= '0;
      sdi_m  <= '0;
      hold_m <= '1;
      sck_d  <= 1'b0;
      cs_d   <= 1'b0;
    end else begin
      sck_m  <= {sck_m[0], sck_i};
      cs_m   <= {cs_m[0], cs_n_i};
      sdi_m  <= {sdi_m[0], sdi_i};
      hold_m <= {hold_m[0], hold_n_i};
      sck_d  <= sck_m[1];
      cs_d   <= cs_m[1];
    end
  end

  logic sck_s, cs_s, sdi_s, holdn_s;
  assign sck_s   = sck_m[1];
  assign cs_s    = cs_m[1];
  assign sdi_s   = sdi_m[1];
  assign holdn_s = hold_m[1];

  logic rise, fall, cs_fall, cs_rise;
  assign rise    = sck_s & ~sck_d;
  assign fall    = ~sck_s & sck_d;
  assign cs_fall = ~cs_s & cs_d;
  assign cs_rise = cs_s & ~cs_d;

  logic armed, hold_q, sel, act;
  assign sel = ~cs_s & (armed | cs_fall);
  assign act = sel & ~hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       armed <= 1'b0;
    else if (cs_fall) armed <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hold_q <= 1'b0;
    else if (!sel)   hold_q <= 1'b0;
    else if (!sck_s) hold_q <= ~holdn_s;
  end

  logic [W-1:0]  rx_sh;
  logic [CW-1:0] bit_cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_sh      <= '0;
      bit_cnt_q  <= '0;
      rx_valid_o <= 1'b0;
      rx_byte_o  <= '0;
    end else begin
      rx_valid_o <= 1'b0;
      if (!sel) begin
        rx_sh     <= '0;
        bit_cnt_q <= '0;
      end else if (act && rise) begin
        rx_sh     <= {rx_sh[W-2:0], sdi_s};
        bit_cnt_q <= (bit_cnt_q == LAST) ? '0 : bit_cnt_q + 1'b1;
        if (bit_cnt_q == LAST) begin
          rx_valid_o <= 1'b1;
          rx_byte_o  <= {rx_sh[W-2:0], sdi_s};
        end
      end
    end
  end

  assign bit_cnt_o = bit_cnt_q;
  assign tx_req_o  = rx_valid_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      desel_o         <= 1'b0;
      desel_aligned_o <= 1'b0;
    end else begin
      desel_o         <= cs_rise & armed;
      desel_aligned_o <= cs_rise & armed & (bit_cnt_q == '0);
    end
  end

  logic [W-1:0] tx_buf, tx_sh;
  logic tx_pend, tx_act, out_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_buf  <= '0;
      tx_sh   <= '0;
      tx_pend <= 1'b0;
      tx_act  <= 1'b0;
      out_bit <= 1'b0;
    end else if (!sel) begin
      tx_sh   <= '0;
      tx_pend <= 1'b0;
      tx_act  <= 1'b0;
      out_bit <= 1'b0;
    end else begin
      if (act && fall) begin
        if (tx_pend) begin
          out_bit <= tx_buf[W-1];
          tx_sh   <= {tx_buf[W-2:0], 1'b0};
          tx_pend <= 1'b0;
          tx_act  <= 1'b1;
        end else if (tx_act) begin
          out_bit <= tx_sh[W-1];
          tx_sh   <= {tx_sh[W-2:0], 1'b0};
        end
      end
      if (tx_load_i) begin
        tx_buf  <= tx_byte_i;
        tx_pend <= 1'b1;
      end
    end
  end

  assign sdo_o    = out_bit;
  assign sdo_oe_o = act & tx_act;

  // R2
  byte_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |-> (bit_cnt_q == '0) && ($past(bit_cnt_q) == LAST));

  // R4
  lockout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> (bit_cnt_q == '0) && !rx_valid_o && !tx_act);

  // R6
  hold_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_q) |-> $past(!sck_s));

  // R6
  hold_leave_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(hold_q) && $past(sel)) |-> $past(!sck_s));

  // R7
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && $past(hold_q) && sel && $past(sel)) |-> ($stable(bit_cnt_q) && $stable(rx_sh) && $stable(tx_sh)));

  // R5
  out_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_oe_o && $past(sdo_oe_o) && (sdo_o != $past(sdo_o))) |-> $past(fall));

  // R9
  desel_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    desel_o |-> ($past(cs_s) && $past(!cs_d)));
endmodule

// File: tb/spi_hold_frontend_test.sv
module spi_hold_frontend_test;
  localparam int H = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b0, sdi = 1'b0, hold_n = 1'b1;
  logic tx_load = 1'b0;
  logic [7:0] tx_byte = '0;
  logic sdo, sdo_oe, rx_valid, tx_req, desel, desel_al;
  logic [7:0] rx_byte;
  logic [2:0] bit_cnt;

  int checks = 0, failures = 0, desel_cnt = 0;
  bit last_al = 1'b0;
  logic [7:0] exp_q[$];

  spi_hold_frontend #(.W(8)) uut (
    .clk(clk), .rst_n(rst_n), .sck_i(sck), .cs_n_i(cs_n), .sdi_i(sdi), .hold_n_i(hold_n),
    .sdo_o(sdo), .sdo_oe_o(sdo_oe), .rx_valid_o(rx_valid), .rx_byte_o(rx_byte),
    .bit_cnt_o(bit_cnt), .tx_req_o(tx_req), .tx_load_i(tx_load), .tx_byte_i(tx_byte),
    .desel_o(desel), .desel_aligned_o(desel_al));

  always #4 clk = ~clk;

  task automatic chk(input string req, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(negedge clk) begin
    if (rst_n && rx_valid) begin
      if (exp_q.size() == 0) chk("R4 unexpected byte", 1'b0, rx_byte, 0);
      else begin
        automatic logic [7:0] e = exp_q.pop_front();
        chk("R1 byte", rx_byte == e, rx_byte, e);
        chk("R5 tx_req", tx_req == 1'b1, tx_req, 1);
      end
    end
    if (rst_n && desel) begin
      desel_cnt++;
      last_al = desel_al;
    end
  end

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sbit(input bit m3, input bit b, input bit ld, input logic [7:0] lb,
                      output bit s, output bit oe);
    if (m3) sck = 1'b0;
    sdi = b;
    w(H);
    s = sdo; oe = sdo_oe;
    sck = 1'b1;
    w(5);
    if (ld) begin tx_byte = lb; tx_load = 1'b1; w(1); tx_load = 1'b0; end
    else w(1);
    w(H - 6);
    if (!m3) sck = 1'b0;
  endtask

  task automatic xfer(input bit m3, input logic [7:0] mosi, input bit ld, input logic [7:0] lb,
                      output logic [7:0] miso, output bit oe_all);
    bit s, oe;
    exp_q.push_back(mosi);
    oe_all = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      sbit(m3, mosi[i], ld && i == 0, lb, s, oe);
      miso[i] = s;
      oe_all &= oe;
    end
  endtask

  task automatic cs_low();  cs_n = 1'b0; w(6); endtask
  task automatic cs_high(); w(4); cs_n = 1'b1; w(8); endtask

  initial begin
    logic [7:0] miso;
    bit oe_all, s, oe;
    int dc;
    w(3);
    rst_n = 1'b1;
    w(4);
    chk("R3 reset oe", sdo_oe == 1'b0, sdo_oe, 0);
    chk("R2 reset count", bit_cnt == 0, bit_cnt, 0);

    // R4: select held low through reset; activity must be ignored
    for (int i = 0; i < 8; i++) sbit(0, 1'b1, 0, 8'h00, s, oe);
    w(8);
    chk("R4 locked count", bit_cnt == 0, bit_cnt, 0);
    cs_n = 1'b1; w(8);
    chk("R9 no strobe while locked", desel_cnt == 0, desel_cnt, 0);

    // R1 R9: mode 0 write of two bytes, aligned end
    cs_low();
    xfer(0, 8'hB4, 0, 8'h00, miso, oe_all);
    xfer(0, 8'h2D, 0, 8'h00, miso, oe_all);
    chk("R5 no load keeps oe low", oe_all == 1'b0, oe_all, 0);
    dc = desel_cnt;
    cs_high();
    chk("R9 strobe", desel_cnt == dc + 1, desel_cnt, dc + 1);
    chk("R9 aligned", last_al == 1'b1, last_al, 1);

    // R2 R9 R3: partial byte then deselect
    cs_low();
    for (int i = 0; i < 5; i++) sbit(0, 1'b1, 0, 8'h00, s, oe);
    w(6);
    chk("R2 count five", bit_cnt == 5, bit_cnt, 5);
    cs_high();
    chk("R9 unaligned", last_al == 1'b0, last_al, 0);
    chk("R3 count cleared", bit_cnt == 0, bit_cnt, 0);

    // R5: mode 0 streamed read
    cs_low();
    xfer(0, 8'h03, 1, 8'hA5, miso, oe_all);
    xfer(0, 8'h00, 1, 8'h3C, miso, oe_all);
    chk("R5 first byte mode0", miso == 8'hA5, miso, 8'hA5);
    chk("R5 oe driven", oe_all == 1'b1, oe_all, 1);
    xfer(0, 8'hFF, 0, 8'h00, miso, oe_all);
    chk("R5 streamed byte", miso == 8'h3C, miso, 8'h3C);
    cs_high();
    chk("R3 oe off", sdo_oe == 1'b0, sdo_oe, 0);

    // R1 R5: mode 3 (clock idles high)
    sck = 1'b1; w(8);
    cs_low();
    xfer(1, 8'h0B, 1, 8'h96, miso, oe_all);
    xfer(1, 8'h12, 0, 8'h00, miso, oe_all);
    chk("R5 byte mode3", miso == 8'h96, miso, 8'h96);
    cs_high();

    // R6 R7: mode 3, hold entered with clock low
    cs_low();
    exp_q.push_back(8'hC3);
    for (int i = 7; i >= 4; i--) sbit(1, 8'hC3 >> i, 0, 8'h00, s, oe);
    sck = 1'b0; w(8);
    hold_n = 1'b0; w(8);
    for (int i = 0; i < 3; i++) begin sdi = ~sdi; sck = 1'b1; w(4); sck = 1'b0; w(4); end
    chk("R7 count frozen", bit_cnt == 4, bit_cnt, 4);
    hold_n = 1'b1; w(8);
    for (int i = 3; i >= 0; i--) sbit(1, 8'hC3 >> i, 0, 8'h00, s, oe);
    cs_high();
    sck = 1'b0; w(8);

    // R6 R7: mode 0 read, hold toggled while clock high
    cs_low();
    xfer(0, 8'h05, 1, 8'hA5, miso, oe_all);
    exp_q.push_back(8'h5A);
    sdi = 1'b0; w(H);
    miso[7] = sdo;
    sck = 1'b1; w(2);
    hold_n = 1'b0; w(6);
    chk("R6 entry deferred", sdo_oe == 1'b1, sdo_oe, 1);
    sck = 1'b0; w(8);
    chk("R7 oe off in hold", sdo_oe == 1'b0, sdo_oe, 0);
    chk("R6 count at entry", bit_cnt == 1, bit_cnt, 1);
    for (int i = 0; i < 2; i++) begin sdi = ~sdi; sck = 1'b1; w(4); sck = 1'b0; w(4); end
    chk("R7 junk ignored", bit_cnt == 1, bit_cnt, 1);
    sck = 1'b1; w(4);
    hold_n = 1'b1; w(6);
    chk("R6 exit deferred", sdo_oe == 1'b0, sdo_oe, 0);
    sck = 1'b0; w(8);
    chk("R6 resumed", sdo_oe == 1'b1, sdo_oe, 1);
    for (int i = 6; i >= 0; i--) begin
      sbit(0, 8'h5A >> i, 0, 8'h00, s, oe);
      miso[i] = s;
    end
    chk("R7 read across hold", miso == 8'hA5, miso, 8'hA5);
    cs_high();

    // R8: deselect during hold resets everything
    cs_low();
    for (int i = 0; i < 3; i++) sbit(0, 1'b1, 0, 8'h00, s, oe);
    w(4);
    chk("R2 count three", bit_cnt == 3, bit_cnt, 3);
    hold_n = 1'b0; w(8);
    dc = desel_cnt;
    cs_n = 1'b1; w(8);
    chk("R8 count reset", bit_cnt == 0, bit_cnt, 0);
    chk("R8 strobe in hold", desel_cnt == dc + 1 && last_al == 1'b0, desel_cnt, dc + 1);
    hold_n = 1'b1; w(4);
    cs_low();
    xfer(0, 8'h81, 0, 8'h00, miso, oe_all);
    cs_high();
    chk("R8 fresh byte after reset", last_al == 1'b1, last_al, 1);

    w(10);
    chk("R1 all bytes seen", exp_q.size() == 0, exp_q.size(), 0);
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk("watchdog", 1'b0, 0, 1);
    finish_run();
  end
endmodule